// File: doc/BRIEF.md
# Triggered Two-Channel DAC Waveform Generator

This block is the digital core behind a pair of DAC channels. Each channel watches one of eight shared trigger lines, chosen by its own select field and gated by its own enable bit. A trigger latches the channel's 12-bit holding value and adds a wave term to it. The term is zero, a masked pseudo-random word, or the value of a triangle counter. The saturated sum reaches the channel's output register a fixed three clock edges after the trigger edge. Once the sum is formed, the generator for the selected wave advances by one step.

Each channel has its own noise register, its own triangle counter and its own amplitude code. The two channels can therefore run different waves at different rates. A trigger that arrives while a channel's transfer is still pending is dropped. In that case the channel raises a one-cycle overrun pulse.

Top module: `wavegen_dac_core`

## Requirements
- R1: After reset every output word is 0 and every overrun flag is 0.
- R2: While a channel's enable bit is 0, a pulse on its selected trigger line leaves its output word unchanged and does not advance its generators.
- R3: A channel reacts only to the trigger line whose index equals its 3-bit select field. Pulses on the other seven lines have no effect on it.
- R4: The holding value is sampled at the trigger edge. The output word takes the new value at the third rising edge after the trigger edge and keeps its old value before that edge.
- R5: Wave code 00 copies the holding value to the output unchanged.
- R6: Wave code 01 adds the 12-bit noise word ANDed with a mask whose low n+1 bits are set (n = amplitude code, capped at 12 bits). The noise word starts at 12'hA5B after reset. It shifts left on each noise-mode trigger, taking bit 0 from bit11 ^ bit5 ^ bit3 ^ bit0. Each trigger uses the word from before that trigger's shift.
- R7: Wave codes 10 and 11 add a triangle counter that starts at 0 counting up. On each triangle-mode trigger, after its value is used, the counter steps by one. It turns downward once it is at or above 2^(n+1)-1 (capped at 4095) and turns upward when it reaches 0.
- R8: When the holding value plus the wave term exceeds 4095, the output is 4095.
- R9: A trigger on one channel changes neither the other channel's output nor its generators.
- R10: A selected, enabled trigger seen at any of the three edges after an accepted trigger is ignored. The overrun flag is 1 for the one cycle following that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigLines | input | 8 | Shared trigger lines, sampled at each rising edge |
| trigEn | input | 2 | Per-channel trigger enable |
| trigSel | input | 6 | Per-channel trigger line index, 3 bits per channel |
| waveMode | input | 4 | Per-channel wave code, 2 bits per channel |
| ampCode | input | 8 | Per-channel amplitude code, 4 bits per channel |
| holdData | input | 24 | Per-channel 12-bit holding value |
| dataOut | output | 24 | Per-channel 12-bit output register |
| overrun | output | 2 | Per-channel one-cycle dropped-trigger pulse |

## Verification
The hardest case to reach is a trigger landing inside the three-cycle pending window of the same channel. It has to be dropped with a flag, and it must advance neither the generator nor the captured sum. The stimulus holds a trigger line high across the edge after an accepted trigger. It changes the holding value in the same cycle and then follows with normal triggers, so any extra generator step shows up as a mismatch later in the noise or triangle sequence. Random runs sweep wave codes, amplitude codes and holding values near full scale so that saturation and triangle turn-arounds occur.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;
  // edges between an accepted trigger and the output update
  localparam int XFER_LAT = 3;

  typedef struct packed {
    logic capture;  // latch sum, step generator
    logic load;     // move latched sum into the output register
  } wgStrobe_t;
endpackage

// File: rtl/wg_ctrl.sv
`timescale 1ns/1ps
module wg_ctrl
  import wg_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC),
  localparam int CNTW = $clog2(XFER_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] trigLines,
  input  logic            trigEn,
  input  logic [SELW-1:0] trigSel,
  output wgStrobe_t       strobe,
  output logic            overrun
);
  logic [CNTW-1:0] cntQ;
  logic trigHit, busy;

  assign trigHit        = trigEn && trigLines[trigSel];
  assign busy           = (cntQ != '0);
  assign strobe.capture = trigHit && !busy;
  assign strobe.load    = (cntQ == CNTW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ    <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= trigHit && busy;
      if (strobe.capture) cntQ <= CNTW'(XFER_LAT);
      else if (busy)      cntQ <= cntQ - CNTW'(1);
    end
  end

  p_load_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |-> ##3 strobe.load);

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trigEn |-> !strobe.capture);

  p_no_load_twice_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> !strobe.load);
endmodule

// File: rtl/wg_datapath.sv
`timescale 1ns/1ps
module wg_datapath
  import wg_pkg::*;
#(
  parameter int          DW         = 12,
  parameter logic [DW-1:0] LFSR_TAPS = 12'h829,
  parameter logic [DW-1:0] LFSR_SEED = 12'hA5B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wgStrobe_t     strobe,
  input  logic [DW-1:0] holdData,
  input  logic [1:0]    waveMode,
  input  logic [3:0]    ampCode,
  output logic [DW-1:0] dataOut
);
  logic [DW-1:0] lfsrQ, triQ, sumQ, mask, waveTerm, sumSat;
  logic [DW:0]   sumFull;
  logic          triUp, isNoise, isTri;

  assign isNoise = (waveMode == 2'b01);
  assign isTri   = waveMode[1];

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i <= int'(ampCode));
  end

  always_comb begin
    if (isTri)        waveTerm = triQ;
    else if (isNoise) waveTerm = lfsrQ & mask;
    else              waveTerm = '0;
  end

  assign sumFull = {1'b0, holdData} + {1'b0, waveTerm};
  assign sumSat  = sumFull[DW] ? '1 : sumFull[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsrQ   <= LFSR_SEED;
      triQ    <= '0;
      triUp   <= 1'b1;
      sumQ    <= '0;
      dataOut <= '0;
    end else begin
      if (strobe.capture) begin
        sumQ <= sumSat;
        if (isNoise) lfsrQ <= {lfsrQ[DW-2:0], ^(lfsrQ & LFSR_TAPS)};
        if (isTri) begin
          if (triUp) begin
            if (triQ >= mask) begin
              triUp <= 1'b0;
              triQ  <= triQ - 1'b1;
            end else begin
              triQ  <= triQ + 1'b1;
            end
          end else begin
            if (triQ == '0) begin
              triUp <= 1'b1;
              triQ  <= triQ + 1'b1;
            end else begin
              triQ  <= triQ - 1'b1;
            end
          end
        end
      end
      if (strobe.load) dataOut <= sumQ;
    end
  end

  p_out_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(dataOut));

  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsrQ != '0);

  p_hold_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && waveMode == 2'b00) |=> sumQ == $past(holdData));

  p_tri_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && isTri && !triUp && triQ == '0) |=> triUp);
endmodule

// File: rtl/wavegen_dac_core.sv
`timescale 1ns/1ps
module wavegen_dac_core
  import wg_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int DW   = 12,
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     trigLines,
  input  logic [NCH-1:0]      trigEn,
  input  logic [NCH*SELW-1:0] trigSel,
  input  logic [NCH*2-1:0]    waveMode,
  input  logic [NCH*4-1:0]    ampCode,
  input  logic [NCH*DW-1:0]   holdData,
  output logic [NCH*DW-1:0]   dataOut,
  output logic [NCH-1:0]      overrun
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    wgStrobe_t strb;

    wg_ctrl #(.NSRC(NSRC)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .trigLines(trigLines),
      .trigEn   (trigEn[ch]),
      .trigSel  (trigSel[ch*SELW +: SELW]),
      .strobe   (strb),
      .overrun  (overrun[ch])
    );

    wg_datapath #(.DW(DW)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (strb),
      .holdData(holdData[ch*DW +: DW]),
      .waveMode(waveMode[ch*2 +: 2]),
      .ampCode (ampCode[ch*4 +: 4]),
      .dataOut (dataOut[ch*DW +: DW])
    );
  end
endmodule

// File: tb/wavegen_dac_core_test.sv
`timescale 1ns/1ps
module wavegen_dac_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trigLines = '0;
  logic [1:0]  trigEn = '0;
  logic [5:0]  trigSel = '0;
  logic [3:0]  waveMode = '0;
  logic [7:0]  ampCode = '0;
  logic [23:0] holdData = '0;
  logic [23:0] dataOut;
  logic [1:0]  overrun;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [11:0] lfsrM [2];
  logic [11:0] triM  [2];
  bit          upM   [2];

  always #2.5 clk = ~clk;

  wavegen_dac_core uut (.*);

  function automatic logic [11:0] maskOf(logic [3:0] amp);
    logic [11:0] m;
    for (int i = 0; i < 12; i++) m[i] = (i <= int'(amp));
    return m;
  endfunction

  function automatic logic [11:0] outOf(int ch);
    return dataOut[ch*12 +: 12];
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // expected output for one accepted trigger, then model step
  task automatic modelStep(int ch, logic [1:0] mode, logic [3:0] amp,
                           logic [11:0] hold, output logic [11:0] expv);
    logic [11:0] wave;
    int s;
    logic [11:0] m;
    m = maskOf(amp);
    if (mode[1])          wave = triM[ch];
    else if (mode == 2'b01) wave = lfsrM[ch] & m;
    else                  wave = '0;
    s = int'(hold) + int'(wave);
    expv = (s > 4095) ? 12'hFFF : 12'(s);
    if (mode == 2'b01)
      lfsrM[ch] = {lfsrM[ch][10:0], lfsrM[ch][11]^lfsrM[ch][5]^lfsrM[ch][3]^lfsrM[ch][0]};
    if (mode[1]) begin
      if (upM[ch]) begin
        if (triM[ch] >= m) begin upM[ch] = 0; triM[ch] = triM[ch] - 1; end
        else triM[ch] = triM[ch] + 1;
      end else begin
        if (triM[ch] == 0) begin upM[ch] = 1; triM[ch] = triM[ch] + 1; end
        else triM[ch] = triM[ch] - 1;
      end
    end
  endtask

  task automatic setup(int ch, logic [2:0] sel, logic [1:0] mode,
                       logic [3:0] amp, logic [11:0] hold);
    trigSel[ch*3 +: 3]   = sel;
    waveMode[ch*2 +: 2]  = mode;
    ampCode[ch*4 +: 4]   = amp;
    holdData[ch*12 +: 12] = hold;
  endtask

  // one accepted trigger on channel ch, other channel disabled
  task automatic fire(int ch, logic [2:0] sel, logic [1:0] mode,
                      logic [3:0] amp, logic [11:0] hold, string req);
    logic [11:0] expv, prev, other;
    @(negedge clk);
    setup(ch, sel, mode, amp, hold);
    trigEn = '0; trigEn[ch] = 1'b1;
    modelStep(ch, mode, amp, hold, expv);
    prev  = outOf(ch);
    other = outOf(1-ch);
    trigLines[sel] = 1'b1;
    @(negedge clk);                       // after trigger edge
    trigLines = '0;
    holdData[ch*12 +: 12] = ~hold;        // R4: later changes not captured
    @(negedge clk);                       // after edge 1
    chk(outOf(ch) == prev, "R4 early1", outOf(ch), prev);
    @(negedge clk);                       // after edge 2
    chk(outOf(ch) == prev, "R4 early2", outOf(ch), prev);
    @(negedge clk);                       // after edge 3
    chk(outOf(ch) == expv, req, outOf(ch), expv);
    chk(outOf(1-ch) == other, "R9 other channel", outOf(1-ch), other);
  endtask

  task automatic quiet(int ch, string req);
    logic [11:0] prev;
    prev = outOf(ch);
    repeat (5) @(negedge clk);
    chk(outOf(ch) == prev, req, outOf(ch), prev);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] expv, e0, e1, hold0;
    int dummy;
    dummy = $urandom(1234);
    for (int c = 0; c < 2; c++) begin lfsrM[c] = 12'hA5B; triM[c] = 0; upM[c] = 1; end

    repeat (3) @(negedge clk);
    chk(dataOut == 0, "R1 outputs", int'(dataOut), 0);
    chk(overrun == 0, "R1 overrun", int'(overrun), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 plain copy
    fire(0, 3'd2, 2'b00, 4'd5, 12'd1234, "R5 copy");
    fire(1, 3'd7, 2'b00, 4'd0, 12'd77,   "R5 copy ch1");

    // R2 disabled channel: no output change, no generator step
    @(negedge clk);
    setup(0, 3'd4, 2'b01, 4'd11, 12'd10);
    trigEn = '0;
    trigLines[4] = 1'b1;
    @(negedge clk); trigLines = '0;
    quiet(0, "R2 disabled");

    // R3 other lines ignored
    @(negedge clk);
    setup(0, 3'd2, 2'b01, 4'd11, 12'd10);
    trigEn = 2'b01;
    trigLines = 8'b1111_1011;
    @(negedge clk); trigLines = '0;
    quiet(0, "R3 wrong line");

    // R6 noise, first uses seed
    fire(0, 3'd2, 2'b01, 4'd11, 12'd0, "R6 noise seed");
    fire(0, 3'd2, 2'b01, 4'd3,  12'd100, "R6 noise mask");

    // R7 triangle amp 1: 0,1,2,3,2,1,0,1
    for (int k = 0; k < 8; k++) fire(1, 3'd5, 2'b10, 4'd1, 12'd0, "R7 triangle");

    // R8 saturation
    fire(0, 3'd1, 2'b01, 4'd11, 12'hFFF, "R8 saturate");
    chk(outOf(0) == 12'hFFF, "R8 full scale", outOf(0), 12'hFFF);

    // R10 retrigger during pending window
    @(negedge clk);
    hold0 = 12'd300;
    setup(1, 3'd6, 2'b11, 4'd2, hold0);
    trigEn = 2'b10;
    modelStep(1, 2'b11, 4'd2, hold0, expv);
    trigLines[6] = 1'b1;
    @(negedge clk);                       // accepted edge passed
    holdData[12 +: 12] = 12'd999;         // still high into edge 1
    @(negedge clk);
    chk(overrun[1] == 1'b1, "R10 flag", overrun[1], 1);
    chk(overrun[0] == 1'b0, "R10 flag other", overrun[0], 0);
    trigLines = '0;
    @(negedge clk);
    chk(overrun[1] == 1'b0, "R10 single cycle", overrun[1], 0);
    @(negedge clk);
    chk(outOf(1) == expv, "R10 first sum kept", outOf(1), expv);
    // next trigger exposes any extra generator step
    fire(1, 3'd6, 2'b11, 4'd2, 12'd300, "R10 no extra step");

    // both channels at once, R9
    @(negedge clk);
    setup(0, 3'd0, 2'b01, 4'd7, 12'd50);
    setup(1, 3'd3, 2'b10, 4'd2, 12'd60);
    trigEn = 2'b11;
    modelStep(0, 2'b01, 4'd7, 12'd50, e0);
    modelStep(1, 2'b10, 4'd2, 12'd60, e1);
    trigLines = 8'b0000_1001;
    @(negedge clk); trigLines = '0;
    repeat (3) @(negedge clk);
    chk(outOf(0) == e0, "R9 dual ch0", outOf(0), e0);
    chk(outOf(1) == e1, "R9 dual ch1", outOf(1), e1);

    // random mix
    for (int k = 0; k < 80; k++) begin
      int ch;
      logic [1:0] md;
      ch = $urandom_range(0, 1);
      md = 2'($urandom_range(0, 3));
      fire(ch, 3'($urandom_range(0, 7)), md, 4'($urandom_range(0, 15)),
           (k % 4 == 0) ? 12'($urandom_range(3900, 4095)) : 12'($urandom_range(0, 4095)),
           md == 2'b00 ? "R5 random" : (md == 2'b01 ? "R6 random" : "R7 random"));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule